// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of up to 32. Each bank provides the following:
- a synchronized view of its pad levels;
- a direction register;
- write-one registers that raise and lower the output latches;
- separate enables for rising and falling edges;
- a sticky edge-status register cleared by writing ones;
- a mask that chooses which status bits reach the shared interrupt line.

Pad inputs pass through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one before it. Software reaches each register with single-cycle writes and combinational reads on a plain select/write-enable bus.

The bank count and the pin count of the last bank are parameters. A per-pin parameter mask reverses the meaning of the direction bit for selected pins.

Registers are grouped by function at a 4-byte bank stride. Banks 0 to 2 use the low window. Banks 3 and above use a second window at 0x100.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, and while `rst_n` is low, these hold: every direction bit is 0, every output latch is 0, all edge enables, status bits and mask bits are 0, and `irq` is 0. Because direction bits are 0, `pad_oe` equals the inversion mask.
- R2: A register is addressed as function base + bank offset.
  - Function bases: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C.
  - Bank offset: bank×4 for banks 0 to 2, and 0x100 + (bank−3)×4 for banks 3 and above.
  - Direction, edge enables and mask read back what was written.
- R3: Writing the set register raises the output latch of every pin whose data bit is 1. Pins with a 0 bit keep their latch. The set register reads as 0.
- R4: Writing the clear register lowers the output latch of every pin whose data bit is 1. Pins with a 0 bit keep their latch. The clear register reads as 0.
- R5: `pad_oe` of a pin equals its direction bit, except for pins whose bit in the `INV_MASK` parameter is 1, where it is the inverse. The default parameter value inverts pins 60 to 63.
- R6: The level register returns the pad input two clock edges after it is applied, whatever the pin's direction.
- R7: A status bit sets on a synchronized rising transition when its rising enable is 1, and on a falling transition when its falling enable is 1. Once set, it stays set.
- R8: Writing ones to the status register clears those bits, and zero bits are kept. If an edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R9: `irq` is high exactly when some bank has a status bit whose mask bit is 1.
- R10: Unimplemented pins of the last bank read as 0 and ignore writes. Addresses that decode to no register, or to a bank beyond the bank count, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_sel` is high and `bus_we` is low |
| pad_in | input | NPINS | Pad input levels (NPINS = (NUM_BANKS−1)×32 + LAST_PINS) |
| pad_out | output | NPINS | Output latches |
| pad_oe | output | NPINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions of the status register can land on the same clock edge: a synchronized pad edge setting a bit, and a write-one-to-clear of that same bit. The bench provokes this by counting the synchronizer stages exactly. It drops a pad, lets two edges pass, and presents a status write at the third edge. That write clears the target bit together with another bit that has no new event. The read-back must show the struck bit still set and the other bit gone, which separates set-wins from clear-wins and from a write that was ignored.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned LANE_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned WIN_BANKS = 3;   // banks held by each address window
  localparam int unsigned FN_STRIDE = 12;  // bytes between function groups
  localparam int unsigned MASK_SLOT = 13;  // 0x9C / FN_STRIDE

  typedef enum logic [2:0] {
    FN_LEVEL = 3'd0,
    FN_DIR   = 3'd1,
    FN_SET   = 3'd2,
    FN_CLR   = 3'd3,
    FN_RISE  = 3'd4,
    FN_FALL  = 3'd5,
    FN_STAT  = 3'd6,
    FN_MASK  = 3'd7
  } fn_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output fn_e               fn
);
  logic [7:0] lo;
  logic [7:0] slot;
  logic [3:0] sub;
  logic [3:0] bnk;
  logic       slot_ok;

  always_comb begin
    lo   = addr[7:0];
    slot = lo / 8'(FN_STRIDE);
    sub  = 4'(lo - 8'(slot * 8'(FN_STRIDE)));
    bnk  = {2'b00, sub[3:2]} + (addr[8] ? 4'(WIN_BANKS) : 4'd0);
    fn      = FN_LEVEL;
    slot_ok = 1'b1;
    if (slot < 8'd7)                   fn = fn_e'(slot[2:0]);
    else if (slot == 8'(MASK_SLOT))    fn = FN_MASK;
    else                               slot_ok = 1'b0;
    hit  = slot_ok && (sub[1:0] == 2'b00) && (addr[11:9] == 3'b000)
           && (int'(bnk) < int'(NUM_BANKS));
    bank = bnk[BANK_W-1:0];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned      WIDTH = 32,
  parameter logic [WIDTH-1:0] INV   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  input  logic             wr_en,
  input  fn_e              fn,
  input  logic [WIDTH-1:0] wdata,
  output logic [31:0]      rdata,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] stat_o,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] sync1_q, sync2_q, prev_q;
  logic [WIDTH-1:0] dir_q, out_q, rise_q, fall_q, stat_q, mask_q;
  logic [WIDTH-1:0] dir_d, out_d, rise_d, fall_d, stat_d, mask_d;
  logic [WIDTH-1:0] ev;
  logic             cfg_en, stat_en;

  // next-state
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    rise_d = rise_q;
    fall_d = fall_q;
    mask_d = mask_q;
    if (wr_en) begin
      case (fn)
        FN_DIR:  dir_d  = wdata;
        FN_SET:  out_d  = out_q | wdata;
        FN_CLR:  out_d  = out_q & ~wdata;
        FN_RISE: rise_d = wdata;
        FN_FALL: fall_d = wdata;
        FN_MASK: mask_d = wdata;
        default: ;
      endcase
    end
    ev     = (sync2_q & ~prev_q & rise_q) | (~sync2_q & prev_q & fall_q);
    stat_d = stat_q;
    if (wr_en && fn == FN_STAT) stat_d = stat_d & ~wdata;
    stat_d  = stat_d | ev;          // a fresh edge wins over the clear
    cfg_en  = wr_en;
    stat_en = (wr_en && fn == FN_STAT) || (|ev);
  end

  // synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (cfg_en) begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      mask_q <= mask_d;
    end
  end

  // sticky status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_comb begin
    case (fn)
      FN_LEVEL: rdata = 32'(sync2_q);
      FN_DIR:   rdata = 32'(dir_q);
      FN_RISE:  rdata = 32'(rise_q);
      FN_FALL:  rdata = 32'(fall_q);
      FN_STAT:  rdata = 32'(stat_q);
      FN_MASK:  rdata = 32'(mask_q);
      default:  rdata = 32'd0;
    endcase
  end

  assign out_o  = out_q;
  assign oe_o   = dir_q ^ INV;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned LAST_PINS = 20,
  localparam int unsigned NPINS    = (NUM_BANKS - 1) * LANE_W + LAST_PINS,
  parameter logic [NPINS-1:0] INV_MASK = NPINS'(64'hF000_0000_0000_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              rst_i_n;
  logic              hit;
  logic [BANK_W-1:0] bank_sel;
  fn_e               fn;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NPINS-1:0]  stat_all, mask_all;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .addr(bus_addr), .hit(hit), .bank(bank_sel), .fn(fn)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned W  = (b == NUM_BANKS - 1) ? LAST_PINS : LANE_W;
    localparam int unsigned LO = b * LANE_W;
    logic wr_b;
    assign wr_b = bus_sel && bus_we && hit && (int'(bank_sel) == b);
    gpio_bank #(.WIDTH(W), .INV(INV_MASK[LO +: W])) u_bank (
      .clk(clk), .rst_n(rst_i_n), .pad_i(pad_in[LO +: W]),
      .wr_en(wr_b), .fn(fn), .wdata(bus_wdata[W-1:0]), .rdata(bank_rd[b]),
      .out_o(pad_out[LO +: W]), .oe_o(pad_oe[LO +: W]),
      .stat_o(stat_all[LO +: W]), .mask_o(mask_all[LO +: W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) bus_rdata = bank_rd[bank_sel];
  end

  assign irq = |(stat_all & mask_all);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned NPINS = 116
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] st_all,
  input logic [NPINS-1:0] mk_all
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_out == '0 && !irq));

  // R3 R4
  out_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_out) |-> $past(bus_sel && bus_we));

  // R5
  oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |-> $past(bus_sel && bus_we));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_all) & ~st_all)) |-> $past(bus_sel && bus_we));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((st_all != $past(st_all)) || (mk_all != $past(mk_all))));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .st_all(stat_all), .mk_all(mask_all)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
  localparam int NPINS = 116;
  localparam logic [NPINS-1:0] INV = NPINS'(64'hF000_0000_0000_0000);

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h00C, 32'h0,         32'h0,         4'd1},  // R1 dir bank0
    '{1'b0, 12'h19C, 32'h0,         32'h0,         4'd1},  // R1 mask bank3
    '{1'b1, 12'h00C, 32'h0000_00FF, 32'h0,         4'd2},
    '{1'b0, 12'h00C, 32'h0,         32'h0000_00FF, 4'd2},  // R2
    '{1'b1, 12'h018, 32'h0000_0F0F, 32'h0,         4'd3},
    '{1'b1, 12'h024, 32'h0000_0003, 32'h0,         4'd4},
    '{1'b1, 12'h10C, 32'hFFFF_FFFF, 32'h0,         4'd10},
    '{1'b0, 12'h10C, 32'h0,         32'h000F_FFFF, 4'd10}, // R10
    '{1'b1, 12'h038, 32'hA5A5_A5A5, 32'h0,         4'd2},
    '{1'b0, 12'h038, 32'h0,         32'hA5A5_A5A5, 4'd2},
    '{1'b0, 12'h044, 32'h0,         32'h0,         4'd2},
    '{1'b1, 12'h0A0, 32'h1234_5678, 32'h0,         4'd2},
    '{1'b0, 12'h0A0, 32'h0,         32'h1234_5678, 4'd2},
    '{1'b0, 12'h09C, 32'h0,         32'h0,         4'd2},
    '{1'b0, 12'h018, 32'h0,         32'h0,         4'd3},  // R3 reads zero
    '{1'b0, 12'h060, 32'h0,         32'h0,         4'd10},
    '{1'b0, 12'h110, 32'h0,         32'h0,         4'd10}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic             bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe;
  logic             irq;
  int               n_chk = 0, n_bad = 0;
  logic [31:0]      rv;

  always #5 clk = ~clk;

  gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    do_reset();
    // R1 reset state at the ports
    chk("R1 pad_out", 128'(pad_out), 128'(0));
    chk("R1 pad_oe", 128'(pad_oe), 128'(INV));
    chk("R1 irq", 128'(irq), 128'(0));

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, rv);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), 128'(rv), 128'(VEC[i].exp));
      end
    end
    chk("R3 R4 bank0 latches", 128'(pad_out[31:0]), 128'(32'h0000_0F0C));
    chk("R5 bank0 oe", 128'(pad_oe[31:0]), 128'(32'h0000_00FF));
    chk("R10 bank3 oe", 128'(pad_oe[115:96]), 128'(20'hFFFFF));

    // R5 inverted direction pins 60..63
    wr(12'h010, 32'hF000_0001);
    chk("R5 inverted oe", 128'(pad_oe[63:32]), 128'(32'h0000_0001));

    // R6 level after two edges, even on outputs; bank3 via high window
    @(negedge clk);
    pad_in[31:0] = 32'hDEAD_BEEF;
    pad_in[115:96] = 20'hABCDE;
    rd(12'h000, rv);
    chk("R6 level one edge", 128'(rv), 128'(0));
    rd(12'h000, rv);
    chk("R6 level two edges", 128'(rv), 128'(32'hDEAD_BEEF));
    rd(12'h100, rv);
    chk("R6 R2 bank3 level", 128'(rv), 128'(32'h000A_BCDE));

    // R7 edge detection on bank2 (rise A5A5A5A5, fall 0000FFFF)
    wr(12'h044, 32'h0000_FFFF);
    @(negedge clk);
    pad_in[95:64] = 32'h0000_00FF;
    repeat (4) @(negedge clk);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, rv);
    chk("R8 clear all", 128'(rv), 128'(0));
    @(negedge clk);
    pad_in[95:64] = 32'h0F00_000F;
    repeat (4) @(negedge clk);
    rd(12'h050, rv);
    chk("R7 rise and fall", 128'(rv), 128'(32'h0500_00F0));
    repeat (6) @(negedge clk);
    rd(12'h050, rv);
    chk("R7 sticky", 128'(rv), 128'(32'h0500_00F0));
    wr(12'h050, 32'h0000_00F0);
    rd(12'h050, rv);
    chk("R8 partial clear", 128'(rv), 128'(32'h0500_0000));

    // R8 edge and clear on the same edge: set wins
    @(negedge clk);
    pad_in[64] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h050; bus_wdata = 32'h0100_0001;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(12'h050, rv);
    chk("R8 set wins", 128'(rv), 128'(32'h0400_0001));

    // R9 interrupt masking
    chk("R9 masked", 128'(irq), 128'(0));
    wr(12'h0A4, 32'h0000_0001);
    #1 chk("R9 unmasked", 128'(irq), 128'(1));
    wr(12'h050, 32'h0000_0001);
    #1 chk("R9 cleared", 128'(irq), 128'(0));

    // R3 R4 R10 last bank latches
    wr(12'h118, 32'hFFFF_FFFF);
    chk("R3 bank3 set", 128'(pad_out[115:96]), 128'(20'hFFFFF));
    wr(12'h124, 32'h0000_000F);
    chk("R4 bank3 clear", 128'(pad_out[115:96]), 128'(20'hFFFF0));
    chk("R4 bank0 kept", 128'(pad_out[31:0]), 128'(32'h0000_0F0C));

    // R1 reset mid-run
    do_reset();
    chk("R1 pad_out", 128'(pad_out), 128'(0));
    chk("R1 irq", 128'(irq), 128'(0));
    rd(12'h050, rv);
    chk("R1 status", 128'(rv), 128'(0));
    rd(12'h0A4, rv);
    chk("R1 mask", 128'(rv), 128'(0));
    rd(12'h00C, rv);
    chk("R1 dir", 128'(rv), 128'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule